// File: doc/BRIEF.md
# Per-Pin Selectable Input Filter

This block conditions the synchronised pad levels of a pin bank (32 pins by default) before they reach the data-read and interrupt-detect logic. Each pin can be filtered or left unfiltered. A filtered pin uses one of two time bases. The first is a fast glitch rejector that runs on every system clock. The second is a slow debounce filter that samples on a divided version of an external slow-clock tick. All pins share a single programmable divider for the debounce time base.

Software configures the block through per-pin write-one strobes. One pair of strobes turns the filter on and off. A second pair picks the filter kind. A separate write port loads the shared divider. The current enable bits, kind bits and divider value are always visible on status outputs. Both filters run all the time, so switching a pin between modes does not restart its history. Clock generation is outside this block.

Top module: `pin_input_filter`

## Requirements
- R1: After reset every filter is off (`flt_en_o` = 0), every pin uses the glitch kind (`flt_deb_o` = 0), the divider reads 0, and `pins_o` equals `pins_i`.
- R2: A 1 on bit i of `flt_en_set_i` sets `flt_en_o[i]` from the next cycle onward. A 1 on bit i of `flt_en_clr_i` clears it. If both strobes are 1 for the same pin in the same cycle, the clear wins.
- R3: A 1 on bit i of `sel_deb_i` makes pin i a debounce pin (`flt_deb_o[i]` = 1). A 1 on bit i of `sel_glitch_i` makes it a glitch pin (`flt_deb_o[i]` = 0). If both are 1 in the same cycle, the glitch kind wins.
- R4: A cycle with `div_wr_i` = 1 loads bits 13:0 of `div_data_i` into the divider, and the divider reads back on `div_o` from the next cycle. Bits 31:14 are discarded.
- R5: Clearing a pin's enable changes neither its kind bit nor the shared divider.
- R6: A pin whose filter is off drives `pins_o[i]` = `pins_i[i]` in the same cycle, with no register in the path.
- R7: A glitch-filtered pin takes a new level only after two consecutive system-clock edges have sampled that level. A level that lasts one cycle never reaches the output.
- R8: The debounce time base ticks once every 2×(DIV+1) slow ticks. A debounce-filtered pin takes a new level only after two consecutive debounce ticks have sampled that level, and its output never changes in a cycle that does not follow a debounce tick.
- R9: Each pin is filtered according to its own enable and kind bits, independently of the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Synchronised pad levels |
| slow_tick_i | input | 1 | One-cycle pulse for each slow-clock period |
| flt_en_set_i | input | 32 | Write-one strobes that turn the filter on |
| flt_en_clr_i | input | 32 | Write-one strobes that turn the filter off |
| sel_glitch_i | input | 32 | Write-one strobes that select the glitch kind |
| sel_deb_i | input | 32 | Write-one strobes that select the debounce kind |
| div_wr_i | input | 1 | Divider load strobe |
| div_data_i | input | 32 | Divider write data; only the low 14 bits are kept |
| pins_o | output | 32 | Filtered pin levels |
| flt_en_o | output | 32 | Current filter enable per pin |
| flt_deb_o | output | 32 | Current filter kind per pin (1 = debounce) |
| div_o | output | 14 | Current shared divider |

## Verification
A wrong enable or kind bit shows up on the status outputs one cycle after the strobe. It also shows up on `pins_o` as soon as the pin's input moves: either a bypassed pin lags its input, or a filtered pin follows a one-cycle pulse. A corrupted glitch history appears within two system clocks of a level change. A wrong divider or tick count only appears after a full debounce period, so the bench watches `pins_o` on every cycle against a model of the tick count. It uses several divider values and both a steady and an irregular slow-tick pattern.

// File: rtl/pif_pkg.sv
package pif_pkg;
  typedef enum logic {
    FLT_GLITCH   = 1'b0,
    FLT_DEBOUNCE = 1'b1
  } flt_kind_e;

  localparam int unsigned PIF_NPINS  = 32;
  localparam int unsigned PIF_DIV_W  = 14;
  localparam int unsigned PIF_DATA_W = 32;
endpackage

// File: rtl/pif_cfg.sv
module pif_cfg #(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] en_set_i,
  input  logic [NPINS-1:0] en_clr_i,
  input  logic [NPINS-1:0] sel_glitch_i,
  input  logic [NPINS-1:0] sel_deb_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] deb_o,
  output logic [DIV_W-1:0] div_o
);
  import pif_pkg::*;

  logic [NPINS-1:0] en_q, deb_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      deb_q <= {NPINS{FLT_GLITCH}};
      div_q <= '0;
    end else begin
      en_q  <= (en_q | en_set_i) & ~en_clr_i;     // clear wins
      deb_q <= (deb_q | sel_deb_i) & ~sel_glitch_i; // glitch wins
      if (div_wr_i) div_q <= div_wdata_i;
    end
  end

  assign en_o  = en_q;
  assign deb_o = deb_q;
  assign div_o = div_q;
endmodule

// File: rtl/pif_tick.sv
module pif_tick #(
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  // period 2*(div+1) slow ticks: terminal count 2*div+1
  assign last_cnt = {div_i, 1'b1};
  assign tick_o   = slow_tick_i && (cnt_q >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (slow_tick_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pif_pin.sv
module pif_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic deb_tick_i,
  input  logic en_i,
  input  logic deb_i,
  output logic pin_o
);
  import pif_pkg::*;

  logic g_prev_q, g_out_q, d_prev_q, d_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_prev_q <= 1'b0;
      g_out_q  <= 1'b0;
    end else begin
      g_prev_q <= pin_i;
      if (pin_i == g_prev_q) g_out_q <= pin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_prev_q <= 1'b0;
      d_out_q  <= 1'b0;
    end else if (deb_tick_i) begin
      d_prev_q <= pin_i;
      if (pin_i == d_prev_q) d_out_q <= pin_i;
    end
  end

  always_comb begin
    if (!en_i)                             pin_o = pin_i;
    else if (flt_kind_e'(deb_i) == FLT_DEBOUNCE) pin_o = d_out_q;
    else                                   pin_o = g_out_q;
  end
endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter #(
  parameter int unsigned NPINS  = pif_pkg::PIF_NPINS,
  parameter int unsigned DIV_W  = pif_pkg::PIF_DIV_W,
  parameter int unsigned DATA_W = pif_pkg::PIF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              slow_tick_i,
  input  logic [NPINS-1:0]  flt_en_set_i,
  input  logic [NPINS-1:0]  flt_en_clr_i,
  input  logic [NPINS-1:0]  sel_glitch_i,
  input  logic [NPINS-1:0]  sel_deb_i,
  input  logic              div_wr_i,
  input  logic [DATA_W-1:0] div_data_i,
  output logic [NPINS-1:0]  pins_o,
  output logic [NPINS-1:0]  flt_en_o,
  output logic [NPINS-1:0]  flt_deb_o,
  output logic [DIV_W-1:0]  div_o
);
  logic deb_tick;
  logic unused_div_hi;

  assign unused_div_hi = ^div_data_i[DATA_W-1:DIV_W];

  pif_cfg #(.NPINS(NPINS), .DIV_W(DIV_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_set_i     (flt_en_set_i),
    .en_clr_i     (flt_en_clr_i),
    .sel_glitch_i (sel_glitch_i),
    .sel_deb_i    (sel_deb_i),
    .div_wr_i     (div_wr_i),
    .div_wdata_i  (div_data_i[DIV_W-1:0]),
    .en_o         (flt_en_o),
    .deb_o        (flt_deb_o),
    .div_o        (div_o)
  );

  pif_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_tick_i (slow_tick_i),
    .div_i       (div_o),
    .tick_o      (deb_tick)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pif_pin u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pins_i[i]),
      .deb_tick_i (deb_tick),
      .en_i       (flt_en_o[i]),
      .deb_i      (flt_deb_o[i]),
      .pin_o      (pins_o[i])
    );
  end
endmodule

// File: rtl/pin_input_filter_chk.sv
module pin_input_filter_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DIV_W  = 14,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPINS-1:0]  pins_i,
  input logic [NPINS-1:0]  flt_en_set_i,
  input logic [NPINS-1:0]  flt_en_clr_i,
  input logic [NPINS-1:0]  sel_glitch_i,
  input logic [NPINS-1:0]  sel_deb_i,
  input logic              div_wr_i,
  input logic [DATA_W-1:0] div_data_i,
  input logic [NPINS-1:0]  pins_o,
  input logic [NPINS-1:0]  flt_en_o,
  input logic [NPINS-1:0]  flt_deb_o,
  input logic [DIV_W-1:0]  div_o,
  input logic              deb_tick
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(flt_en_set_i & ~flt_en_clr_i) |=>
      ((flt_en_o & $past(flt_en_set_i & ~flt_en_clr_i)) == $past(flt_en_set_i & ~flt_en_clr_i)));

  p_en_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |flt_en_clr_i |=> ((flt_en_o & $past(flt_en_clr_i)) == '0));

  p_kind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |sel_glitch_i |=> ((flt_deb_o & $past(sel_glitch_i)) == '0));

  p_div_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr_i |=> (div_o == $past(div_data_i[DIV_W-1:0])));

  p_clr_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flt_en_clr_i && !div_wr_i && !(|sel_glitch_i) && !(|sel_deb_i)) |=>
      ($stable(div_o) && $stable(flt_deb_o)));

  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~flt_en_o & (pins_o ^ pins_i)) == '0));

  p_glitch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((($past(flt_en_o & ~flt_deb_o) & flt_en_o & ~flt_deb_o)
                  & (pins_o ^ $past(pins_o)) & (pins_o ^ $past(pins_i))) == '0));

  p_deb_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(deb_tick)) |->
      ((($past(flt_en_o & flt_deb_o) & flt_en_o & flt_deb_o)
        & (pins_o ^ $past(pins_o))) == '0));
endmodule

bind pin_input_filter pin_input_filter_chk #(
  .NPINS(NPINS), .DIV_W(DIV_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pins_i       (pins_i),
  .flt_en_set_i (flt_en_set_i),
  .flt_en_clr_i (flt_en_clr_i),
  .sel_glitch_i (sel_glitch_i),
  .sel_deb_i    (sel_deb_i),
  .div_wr_i     (div_wr_i),
  .div_data_i   (div_data_i),
  .pins_o       (pins_o),
  .flt_en_o     (flt_en_o),
  .flt_deb_o    (flt_deb_o),
  .div_o        (div_o),
  .deb_tick     (deb_tick)
);

// File: tb/test_pin_input_filter.sv
module test_pin_input_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins = '0, en_set = '0, en_clr = '0, s_gl = '0, s_db = '0;
  logic slow = 1'b0, div_wr = 1'b0;
  logic [31:0] div_data = '0;
  logic [NP-1:0] pins_o, en_o, deb_o;
  logic [13:0] div_o;

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_input_filter i_pin_input_filter (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .slow_tick_i(slow),
    .flt_en_set_i(en_set), .flt_en_clr_i(en_clr), .sel_glitch_i(s_gl),
    .sel_deb_i(s_db), .div_wr_i(div_wr), .div_data_i(div_data),
    .pins_o(pins_o), .flt_en_o(en_o), .flt_deb_o(deb_o), .div_o(div_o)
  );

  // behavioural reference model
  logic [NP-1:0] m_en, m_deb, m_glast, m_gout, m_dlast, m_dout;
  int m_grun[NP], m_drun[NP];
  int m_div, m_slow;
  bit m_tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_deb = '0; m_div = 0; m_slow = 0;
      m_glast = '0; m_gout = '0; m_dlast = '0; m_dout = '0;
      for (int i = 0; i < NP; i++) begin m_grun[i] = 1; m_drun[i] = 1; end
    end else begin
      m_tick = 0;
      if (slow) begin
        m_slow = m_slow + 1;
        if (m_slow >= 2 * (m_div + 1)) begin m_tick = 1; m_slow = 0; end
      end
      for (int i = 0; i < NP; i++) begin
        if (pins[i] == m_glast[i]) begin if (m_grun[i] < 2) m_grun[i]++; end
        else m_grun[i] = 1;
        m_glast[i] = pins[i];
        if (m_grun[i] >= 2) m_gout[i] = pins[i];
        if (m_tick) begin
          if (pins[i] == m_dlast[i]) begin if (m_drun[i] < 2) m_drun[i]++; end
          else m_drun[i] = 1;
          m_dlast[i] = pins[i];
          if (m_drun[i] >= 2) m_dout[i] = pins[i];
        end
      end
      m_en  = (m_en | en_set) & ~en_clr;
      m_deb = (m_deb | s_db) & ~s_gl;
      if (div_wr) m_div = int'(div_data & 32'h3FFF);
    end
  end

  function automatic logic [NP-1:0] exp_pins();
    logic [NP-1:0] e;
    for (int i = 0; i < NP; i++)
      e[i] = !m_en[i] ? pins[i] : (m_deb[i] ? m_dout[i] : m_gout[i]);
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [NP-1:0] e, d;
      string tag;
      check("R2 enable status", en_o, m_en);
      check("R3 kind status", deb_o, m_deb);
      check("R4 divider", {18'd0, div_o}, m_div);
      e = exp_pins();
      d = pins_o ^ e;
      tag = "R9 pins";
      for (int i = NP - 1; i >= 0; i--)
        if (d[i]) tag = !m_en[i] ? "R6 bypass" : (m_deb[i] ? "R8 debounce" : "R7 glitch");
      check(tag, pins_o, e);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pins = 32'hA5A5_0F0F;
    step(3);
    @(negedge clk);
    check("R1 reset enables", en_o, '0);
    check("R1 reset kind", deb_o, '0);
    check("R1 reset divider", {18'd0, div_o}, '0);
    check("R1 reset passthrough", pins_o, pins);
    rst_n = 1'b1;
    pins = '0;
    step(3);
    cmp_on = 1;

    // R6 bypass, several patterns
    foreach (pins[k]) begin pins = 32'h1 << k; step(1); end
    pins = 32'hDEAD_BEEF; step(1);
    @(negedge clk); check("R6 bypass same cycle", pins_o, 32'hDEAD_BEEF);
    pins = '0; step(3);

    // glitch on low half, debounce on high half
    s_gl = 32'h0000_FFFF; s_db = 32'hFFFF_0000; div_wr = 1; div_data = 32'hFFFF_C002;
    step(1);
    s_gl = '0; s_db = '0; div_wr = 0;
    @(negedge clk);
    check("R4 divider masked", {18'd0, div_o}, 32'd2);
    check("R3 debounce kind", deb_o, 32'hFFFF_0000);
    en_set = '1; step(1); en_set = '0;
    @(negedge clk); check("R2 enable set", en_o, '1);
    step(3);

    // R7: one-cycle pulse rejected, two-cycle level accepted
    pins[0] = 1; step(1); pins[0] = 0; step(3);
    @(negedge clk); check("R7 pulse rejected", {31'd0, pins_o[0]}, 0);
    pins[1] = 1; step(1);
    @(negedge clk); check("R7 one sample held", {31'd0, pins_o[1]}, 0);
    step(1);
    @(negedge clk); check("R7 two samples pass", {31'd0, pins_o[1]}, 1);

    // R8: debounce with steady slow tick, div 2 -> period 6
    slow = 1;
    pins[16] = 1; step(3);
    @(negedge clk); check("R8 debounce holds early", {31'd0, pins_o[16]}, 0);
    step(12);
    @(negedge clk); check("R8 debounce passes", {31'd0, pins_o[16]}, 1);
    pins[17] = 1; step(40);

    // R2 clear wins, R3 glitch wins
    en_set[5] = 1; en_clr[5] = 1; s_gl[6] = 1; s_db[6] = 1; step(1);
    en_set = '0; en_clr = '0; s_gl = '0; s_db = '0;
    @(negedge clk);
    check("R2 clear wins", {31'd0, en_o[5]}, 0);
    check("R3 glitch wins", {31'd0, deb_o[6]}, 0);

    // R5: disable keeps kind and divider
    en_clr[20] = 1; step(1); en_clr = '0;
    @(negedge clk);
    check("R5 enable cleared", {31'd0, en_o[20]}, 0);
    check("R5 kind kept", {31'd0, deb_o[20]}, 1);
    check("R5 divider kept", {18'd0, div_o}, 32'd2);
    pins[20] = 1; step(1);
    @(negedge clk); check("R6 disabled pin bypass", {31'd0, pins_o[20]}, 1);

    // irregular stimulus, model compared every cycle
    for (int c = 0; c < 6000; c++) begin
      pins = pins ^ ($urandom & $urandom & $urandom);
      slow = ($urandom % 3) != 0;
      en_set = (($urandom % 8) == 0) ? ($urandom & $urandom) : '0;
      en_clr = (($urandom % 8) == 0) ? ($urandom & $urandom) : '0;
      s_gl = (($urandom % 10) == 0) ? ($urandom & $urandom) : '0;
      s_db = (($urandom % 10) == 0) ? $urandom : '0;
      div_wr = ($urandom % 200) == 0;
      div_data = ($urandom & 32'hFFFF_C000) | ($urandom % 4);
      if ((c % 500) < 40) pins = pins & 32'hFFFF_0000; // hold low half for glitch settling
      step(1);
    end
    pins = '0; slow = 0; en_set = '0; en_clr = '0; s_gl = '0; s_db = '0; div_wr = 0;
    step(2);
    @(negedge clk);
    cmp_on = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule